// File: doc/BRIEF.md
# Type-0 Device Configuration Header

This block holds the 64-byte type-0 configuration header of a single PCI device function. An enumerating host reaches it through a simple one-cycle register port. Each access gives a byte offset, a byte count (1, 2 or 4), a write enable or read enable, and write data. The port returns registered read data and an error strobe. All identity fields, the six base address register (BAR) reset values and the six BAR window sizes are fixed by parameters at build time.

Each write is checked against a per-field permission rule, and the rule depends on both the offset and the access size. An all-ones word written to a BAR is a size probe. In response the BAR shows the inverted window mask and keeps its type bits. Which type bits are kept depends on bit 0 of the BAR: I/O or memory. The expansion-ROM BAR has its own probe value. The block also exports the decoded base address of every BAR, together with a flag that shows whether that BAR has ever been given a real address.

Top module: `cfg_hdr`

## Requirements
- R1: After reset the header holds the parameter image. `bar_valid` is 0, `acc_rdata` is 0 and `acc_err` is 0.
- R2: A read at any offset with a size of 1, 2 or 4 returns the bytes at that offset in little-endian order, zero-extended to 32 bits. The data appears on `acc_rdata` in the cycle after `acc_rd`, and `acc_rdata` holds its value while no read occurs.
- R3: A size other than 1, 2 or 4, or an access whose bytes run past offset 63, is invalid. For such an access, `acc_err` is high in the next cycle and no header byte changes. An invalid read returns 0.
- R4: A 1-byte write changes only offset 0x0C (cache-line size) or 0x3C (interrupt line). A 1-byte write to any other offset is an error and changes nothing.
- R5: A 2-byte write is accepted only at offset 0x04 (command) or 0x0C, where it changes bytes 0x0C and 0x0D. A 2-byte write to any other offset is an error and changes nothing.
- R6: A 4-byte write at offset 0x04 updates only the 16-bit command field. The status field at 0x06 is never changed by any write.
- R7: BAR i is at offset 0x10+4i, for i = 0 to 5. A 4-byte write of 0xFFFFFFFF to a BAR loads ~(size_i-1) into the bits above the type bits and keeps the type bits. The type bits are bits 1:0 when bit 0 is 1 (I/O) and bits 3:0 when bit 0 is 0 (memory).
- R8: Any other 4-byte write to a BAR stores the written value with the type bits replaced by the existing type bits.
- R9: A 4-byte write of 0xFFFFFFFE to offset 0x30 (expansion ROM) sets that word to 0xFFFFFFFF. Any other 4-byte value written there is stored unchanged.
- R10: A 4-byte write at any offset other than 0x04, 0x30 or a BAR offset is an error and changes nothing. This includes offsets that are not multiples of 4.
- R11: `bar_base[32i+:32]` equals BAR i with its type bits cleared. `bar_valid[i]` is set by the first non-probe write to BAR i and stays set after later probes and writes.
- R12: Vendor ID, device ID, class code (0x0B), header type (0x0E) and interrupt pin (0x3D) never change after reset.
- R13: `acc_err` is low in the cycle after a valid access or after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write enable; the write commits on this edge |
| acc_rd | input | 1 | Read enable; data is returned the next cycle |
| acc_off | input | 6 | Byte offset into the header |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4 are legal) |
| acc_wdata | input | 32 | Write data, little-endian, in the low bytes |
| acc_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | Registered error strobe for the previous access |
| bar_base | output | 192 | Decoded base address of each BAR, 32 bits per BAR |
| bar_valid | output | 6 | Per-BAR flag: a real address has been written |

## Verification
The properties assume that `acc_off` and `acc_size` are settled in every cycle in which `acc_wr` or `acc_rd` is high. They also assume that the parameter image has a BAR type bit 0 that describes its BAR. No BAR size parameter is made smaller than its type-bit field, so a probe never has to clip the window mask. The bench keeps to these assumptions: it drives every field together on the falling edge and releases them one cycle later. It uses sizes of at least 0x10, and it sends illegal sizes and out-of-range offsets only as deliberate error cases.

// File: rtl/cfg_hdr.sv
`timescale 1ns/1ps
module cfg_hdr #(
  parameter logic [15:0]  VENDOR_ID   = 16'h1234,
  parameter logic [15:0]  DEVICE_ID   = 16'hABCD,
  parameter logic [15:0]  CMD_INIT    = 16'h0000,
  parameter logic [15:0]  STATUS_INIT = 16'h0290,
  parameter logic [7:0]   REV_ID      = 8'h03,
  parameter logic [7:0]   PROG_IF     = 8'h00,
  parameter logic [7:0]   SUBCLASS    = 8'h00,
  parameter logic [7:0]   CLASS_CODE  = 8'h02,
  parameter logic [7:0]   CLS_INIT    = 8'h00,
  parameter logic [7:0]   LAT_INIT    = 8'h00,
  parameter logic [7:0]   HDR_TYPE    = 8'h00,
  parameter logic [7:0]   BIST_INIT   = 8'h00,
  parameter int           NBAR        = 6,
  parameter logic [NBAR*32-1:0] BAR_INIT =
    {96'h0, 32'h0000_0004, 32'h0000_0008, 32'h0000_0001},
  parameter logic [NBAR*32-1:0] BAR_SIZE =
    {32'h10, 32'h10, 32'h10, 32'h0010_0000, 32'h0000_1000, 32'h0000_0100},
  parameter logic [31:0]  CIS_PTR     = 32'h0,
  parameter logic [15:0]  SUBSYS_VID  = 16'h0,
  parameter logic [15:0]  SUBSYS_ID   = 16'h0,
  parameter logic [31:0]  ROM_INIT    = 32'h0,
  parameter logic [7:0]   INT_LINE    = 8'h00,
  parameter logic [7:0]   INT_PIN     = 8'h01,
  parameter logic [7:0]   MIN_GNT     = 8'h00,
  parameter logic [7:0]   MAX_LAT     = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [5:0]        acc_off,
  input  logic [2:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_err,
  output logic [NBAR*32-1:0] bar_base,
  output logic [NBAR-1:0]   bar_valid
);
  localparam int HBYTES  = 64;
  localparam int HBITS   = HBYTES * 8;
  localparam int BAR_LO  = 16;
  localparam int BAR_HI  = BAR_LO + 4 * (NBAR - 1);
  localparam int OFF_CMD = 4;
  localparam int OFF_CLS = 12;
  localparam int OFF_ROM = 48;
  localparam int OFF_IRQ = 60;

  function automatic logic [HBITS-1:0] init_img();
    logic [HBITS-1:0] m;
    m = '0;
    m[0+:16]   = VENDOR_ID;
    m[16+:16]  = DEVICE_ID;
    m[32+:16]  = CMD_INIT;
    m[48+:16]  = STATUS_INIT;
    m[64+:8]   = REV_ID;
    m[72+:8]   = PROG_IF;
    m[80+:8]   = SUBCLASS;
    m[88+:8]   = CLASS_CODE;
    m[96+:8]   = CLS_INIT;
    m[104+:8]  = LAT_INIT;
    m[112+:8]  = HDR_TYPE;
    m[120+:8]  = BIST_INIT;
    for (int i = 0; i < NBAR; i++) m[BAR_LO*8 + i*32 +: 32] = BAR_INIT[i*32 +: 32];
    m[40*8+:32] = CIS_PTR;
    m[44*8+:16] = SUBSYS_VID;
    m[46*8+:16] = SUBSYS_ID;
    m[OFF_ROM*8+:32] = ROM_INIT;
    m[OFF_IRQ*8+:8]  = INT_LINE;
    m[61*8+:8]  = INT_PIN;
    m[62*8+:8]  = MIN_GNT;
    m[63*8+:8]  = MAX_LAT;
    return m;
  endfunction

  logic [HBITS-1:0] hdr, nxt;
  logic [6:0]       span_end;
  logic             size_ok, acc_ok, wr_ok;
  logic [NBAR-1:0]  set_valid;
  logic [HBITS-1:0] shifted;
  logic [31:0]      rd_word;
  logic [5:0]       bar_rel;
  logic [2:0]       bidx;
  logic [31:0]      bsz, bcur, bmask, bval;

  assign size_ok  = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
  assign span_end = {1'b0, acc_off} + {4'b0, acc_size};
  assign acc_ok   = size_ok && (span_end <= 7'd64);

  assign shifted = hdr >> {acc_off, 3'b000};
  always_comb begin
    case (acc_size)
      3'd1:    rd_word = {24'h0, shifted[7:0]};
      3'd2:    rd_word = {16'h0, shifted[15:0]};
      default: rd_word = shifted[31:0];
    endcase
  end

  assign bar_rel = acc_off - 6'(BAR_LO);
  assign bidx    = bar_rel[4:2];
  assign bsz     = BAR_SIZE[bidx*32 +: 32];
  assign bcur    = hdr[BAR_LO*8 + bidx*32 +: 32];
  assign bmask   = bcur[0] ? 32'h3 : 32'hF;
  assign bval    = (acc_wdata == 32'hFFFF_FFFF) ? ~(bsz - 32'd1) : acc_wdata;

  always_comb begin
    nxt       = hdr;
    wr_ok     = 1'b0;
    set_valid = '0;
    if (acc_ok) begin
      case (acc_size)
        3'd1: begin
          if (acc_off == 6'(OFF_CLS)) begin
            nxt[OFF_CLS*8+:8] = acc_wdata[7:0];
            wr_ok = 1'b1;
          end else if (acc_off == 6'(OFF_IRQ)) begin
            nxt[OFF_IRQ*8+:8] = acc_wdata[7:0];
            wr_ok = 1'b1;
          end
        end
        3'd2: begin
          if (acc_off == 6'(OFF_CMD)) begin
            nxt[OFF_CMD*8+:16] = acc_wdata[15:0];
            wr_ok = 1'b1;
          end else if (acc_off == 6'(OFF_CLS)) begin
            nxt[OFF_CLS*8+:16] = acc_wdata[15:0];
            wr_ok = 1'b1;
          end
        end
        3'd4: begin
          if (acc_off == 6'(OFF_CMD)) begin
            nxt[OFF_CMD*8+:16] = acc_wdata[15:0];
            wr_ok = 1'b1;
          end else if (acc_off == 6'(OFF_ROM)) begin
            nxt[OFF_ROM*8+:32] = (acc_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : acc_wdata;
            wr_ok = 1'b1;
          end else if (acc_off >= 6'(BAR_LO) && acc_off <= 6'(BAR_HI) && acc_off[1:0] == 2'b00) begin
            nxt[BAR_LO*8 + bidx*32 +: 32] = (bval & ~bmask) | (bcur & bmask);
            wr_ok = 1'b1;
            if (acc_wdata != 32'hFFFF_FFFF) set_valid[bidx] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr       <= init_img();
      bar_valid <= '0;
      acc_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      if (acc_wr && wr_ok) begin
        hdr       <= nxt;
        bar_valid <= bar_valid | set_valid;
      end
      if (acc_rd) acc_rdata <= acc_ok ? rd_word : 32'h0;
      acc_err <= (acc_wr && !wr_ok) || (acc_rd && !acc_ok);
    end
  end

  for (genvar i = 0; i < NBAR; i++) begin : g_base
    logic [31:0] bv;
    assign bv = hdr[BAR_LO*8 + i*32 +: 32];
    assign bar_base[i*32 +: 32] = bv & (bv[0] ? ~32'h3 : ~32'hF);
  end
endmodule

// File: rtl/cfg_hdr_chk.sv
`timescale 1ns/1ps
module cfg_hdr_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h0,
  parameter logic [15:0] DEVICE_ID = 16'h0,
  parameter int          NBAR      = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_wr,
  input logic            acc_rd,
  input logic [5:0]      acc_off,
  input logic [2:0]      acc_size,
  input logic [31:0]     acc_rdata,
  input logic            acc_err,
  input logic [511:0]    hdr,
  input logic [NBAR-1:0] bar_valid
);
  logic bad_size;
  assign bad_size = !(acc_size == 3'd1 || acc_size == 3'd2 || acc_size == 3'd4);

  a_r12_ident_const: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hdr[31:0]) && $stable(hdr[88+:8]) && $stable(hdr[112+:8]) && $stable(hdr[61*8+:8]));

  a_r6_status_const: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hdr[48+:16]));

  a_r3_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && bad_size) |=> (acc_err && $stable(hdr)));

  a_r10_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(hdr));

  a_r11_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bar_valid & $past(bar_valid)) == $past(bar_valid)));

  a_r2_ident_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_off == 6'd0 && acc_size == 3'd4) |=> (acc_rdata == {DEVICE_ID, VENDOR_ID}));

  a_r13_quiet_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr || acc_rd) |=> !acc_err);

  for (genvar i = 0; i < NBAR; i++) begin : g_bar
    a_r7_space_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(hdr[128 + i*32]));
    a_r8_mem_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr[128 + i*32] |=> $stable(hdr[128 + i*32 +: 4]));
  end
endmodule

bind cfg_hdr cfg_hdr_chk #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .NBAR(NBAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_off(acc_off),
  .acc_size(acc_size), .acc_rdata(acc_rdata), .acc_err(acc_err), .hdr(hdr), .bar_valid(bar_valid)
);

// File: tb/sim_cfg_hdr.sv
`timescale 1ns/1ps
module sim_cfg_hdr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic [5:0]  acc_off = '0;
  logic [2:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_err;
  logic [191:0] bar_base;
  logic [5:0]  bar_valid;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_hdr u0 (.clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_off(acc_off),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
    .bar_base(bar_base), .bar_valid(bar_valid));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(input bit wr, input bit rd, input logic [5:0] off, input logic [2:0] sz,
                     input logic [31:0] d);
    @(negedge clk);
    acc_wr = wr; acc_rd = rd; acc_off = off; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0; acc_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] off, input logic [2:0] sz,
                        input logic [31:0] exp);
    acc(1'b0, 1'b1, off, sz, 32'h0);
    chk(tag, acc_rdata, exp);
    chk({tag, " err"}, {31'h0, acc_err}, 32'h0);
  endtask

  task automatic wr_chk(input string tag, input logic [5:0] off, input logic [2:0] sz,
                        input logic [31:0] d, input bit exp_err);
    acc(1'b1, 1'b0, off, sz, d);
    chk({tag, " err"}, {31'h0, acc_err}, {31'h0, exp_err});
  endtask

  task automatic t_reset;
    chk("R1 rdata", acc_rdata, 32'h0);
    chk("R1 err", {31'h0, acc_err}, 32'h0);
    chk("R1 valid", {26'h0, bar_valid}, 32'h0);
    chk("R11 base0 reset", bar_base[31:0], 32'h0);
    rd_chk("R1 bar1 image", 6'h14, 3'd4, 32'h0000_0008);
  endtask

  task automatic t_reads;
    rd_chk("R2 word0", 6'h00, 3'd4, 32'hABCD_1234);
    rd_chk("R2 half unaligned", 6'h01, 3'd2, 32'h0000_CD12);
    rd_chk("R2 byte class", 6'h0B, 3'd1, 32'h0000_0002);
    rd_chk("R2 last byte", 6'h3F, 3'd1, 32'h0);
    @(negedge clk);
    chk("R2 rdata held", acc_rdata, 32'h0);
  endtask

  task automatic t_bad;
    acc(1'b0, 1'b1, 6'h00, 3'd3, 32'h0);
    chk("R3 size3 rd err", {31'h0, acc_err}, 32'h1);
    chk("R3 size3 rd data", acc_rdata, 32'h0);
    acc(1'b0, 1'b1, 6'h3E, 3'd4, 32'h0);
    chk("R3 past end err", {31'h0, acc_err}, 32'h1);
    wr_chk("R3 size3 wr", 6'h0C, 3'd3, 32'h00FF_FFFF, 1'b1);
    rd_chk("R3 cls untouched", 6'h0C, 3'd2, 32'h0);
    @(negedge clk);
    chk("R13 idle no err", {31'h0, acc_err}, 32'h0);
  endtask

  task automatic t_bytes;
    wr_chk("R4 irq line", 6'h3C, 3'd1, 32'h0000_000B, 1'b0);
    rd_chk("R4 irq line rb", 6'h3C, 3'd2, 32'h0000_010B);
    wr_chk("R4 int pin ro", 6'h3D, 3'd1, 32'h0000_0007, 1'b1);
    rd_chk("R12 int pin kept", 6'h3D, 3'd1, 32'h0000_0001);
    wr_chk("R4 cls byte", 6'h0C, 3'd1, 32'h0000_0020, 1'b0);
    rd_chk("R4 cls rb", 6'h0C, 3'd1, 32'h0000_0020);
  endtask

  task automatic t_halves;
    wr_chk("R5 cls+lat", 6'h0C, 3'd2, 32'h0000_4010, 1'b0);
    rd_chk("R5 cls+lat rb", 6'h0C, 3'd4, 32'h0000_4010);
    wr_chk("R5 vendor ro", 6'h00, 3'd2, 32'h0000_5555, 1'b1);
    rd_chk("R12 vendor kept", 6'h00, 3'd2, 32'h0000_1234);
    wr_chk("R5 cmd half", 6'h04, 3'd2, 32'h0000_0003, 1'b0);
    rd_chk("R5 cmd rb", 6'h04, 3'd2, 32'h0000_0003);
  endtask

  task automatic t_cmd_word;
    wr_chk("R6 cmd word", 6'h04, 3'd4, 32'hFFFF_0007, 1'b0);
    rd_chk("R6 status kept", 6'h04, 3'd4, 32'h0290_0007);
  endtask

  task automatic t_bars;
    wr_chk("R7 io probe", 6'h10, 3'd4, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R7 io probe rb", 6'h10, 3'd4, 32'hFFFF_FF01);
    chk("R11 probe no valid", {26'h0, bar_valid}, 32'h0);
    wr_chk("R7 mem probe", 6'h14, 3'd4, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R7 mem probe rb", 6'h14, 3'd4, 32'hFFFF_F008);
    wr_chk("R7 mem64 probe", 6'h18, 3'd4, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R7 mem64 probe rb", 6'h18, 3'd4, 32'hFFF0_0004);
    wr_chk("R8 io write", 6'h10, 3'd4, 32'hDEAD_BEEF, 1'b0);
    rd_chk("R8 io rb", 6'h10, 3'd4, 32'hDEAD_BEED);
    chk("R11 io base", bar_base[31:0], 32'hDEAD_BEEC);
    wr_chk("R8 mem write", 6'h14, 3'd4, 32'h1234_5677, 1'b0);
    rd_chk("R8 mem rb", 6'h14, 3'd4, 32'h1234_5678);
    chk("R11 mem base", bar_base[63:32], 32'h1234_5670);
    chk("R11 valid set", {26'h0, bar_valid}, 32'h0000_0003);
    wr_chk("R7 reprobe", 6'h14, 3'd4, 32'hFFFF_FFFF, 1'b0);
    chk("R11 valid sticky", {26'h0, bar_valid}, 32'h0000_0003);
    chk("R11 base after probe", bar_base[63:32], 32'hFFFF_F000);
    wr_chk("R8 last bar", 6'h24, 3'd4, 32'hA000_0000, 1'b0);
    chk("R11 bar5 valid", {26'h0, bar_valid}, 32'h0000_0023);
  endtask

  task automatic t_rom;
    wr_chk("R9 rom probe", 6'h30, 3'd4, 32'hFFFF_FFFE, 1'b0);
    rd_chk("R9 rom probe rb", 6'h30, 3'd4, 32'hFFFF_FFFF);
    wr_chk("R9 rom addr", 6'h30, 3'd4, 32'h000C_0001, 1'b0);
    rd_chk("R9 rom addr rb", 6'h30, 3'd4, 32'h000C_0001);
  endtask

  task automatic t_word_err;
    wr_chk("R10 misaligned bar", 6'h12, 3'd4, 32'h1111_1111, 1'b1);
    rd_chk("R10 bar0 kept", 6'h10, 3'd4, 32'hDEAD_BEED);
    wr_chk("R10 ident word", 6'h08, 3'd4, 32'h0000_0000, 1'b1);
    rd_chk("R12 class kept", 6'h08, 3'd4, 32'h0200_0003);
    wr_chk("R10 hdr type word", 6'h0C, 3'd4, 32'hFFFF_FFFF, 1'b1);
    rd_chk("R12 hdr type kept", 6'h0C, 3'd4, 32'h0000_4010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_reads;
    t_bad;
    t_bytes;
    t_halves;
    t_cmd_word;
    t_bars;
    t_rom;
    t_word_err;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule